// File: doc/BRIEF.md
# Remote DMA Byte Transfer Engine

This block moves bytes between a host-facing data port and a local packet buffer. The host uses a small byte-wide register port to set up a transfer. It writes a 16-bit starting buffer address and a 16-bit byte count, each split into a low and a high byte register. It then writes a command code that starts a read, starts a write, or aborts. While a transfer runs, each strobe on the data port moves one byte, or two bytes in word mode, at the current address. The current address then advances and the remaining count drops by the same amount. When the remaining count reaches zero, a completion flag is raised in a status register. The host clears that flag by writing a one to it.

The controller is a three-state machine. IDLE is left on a read command (to READ) or a write command (to WRITE), but only when the effective count is non-zero. READ and WRITE return to IDLE in three cases: the last access, an abort command, or a start command whose effective count is zero. A start command given in READ or WRITE restarts the engine with the newly loaded values. The current address can be read at any time, so the host can poll progress mid-transfer.

Top module: `rdma_engine`

## Requirements
- R1: After reset the current address reads 0x0000 at offsets 0x1 (low) and 0x2 (high), the status register at offset 0x5 reads 0x00, and `dp_rdata` is 0x0000.
- R2: Registers are written through `hs_wr`, `hs_addr` and `hs_wdata`. Start address low and high are at offsets 0x1 and 0x2, and byte count low and high are at offsets 0x3 and 0x4. The command field is bits 5:3 of offset 0x0: 001 is read, 010 is write, 100 is abort. A read or write command copies the start address into the current address.
- R3: In the write state in byte mode, each `dp_wr` stores `dp_wdata[7:0]` at the current address, adds 1 to the address and subtracts 1 from the remaining count.
- R4: In the read state in byte mode, each `dp_rd` places the buffer byte at the current address on `dp_rdata[7:0]` in the cycle after the strobe, with `dp_rdata[15:8]` = 0. It then adds 1 to the address.
- R5: The current address is readable at offsets 0x1 and 0x2 while a transfer is in progress.
- R6: When the remaining count reaches zero, status bit 6 is set and the engine goes idle. Later data-port strobes leave the buffer, the address and `dp_rdata` unchanged.
- R7: A status write (offset 0x5) with bit 6 = 1 clears the completion flag. A write with bit 6 = 0 leaves the flag as it is.
- R8: An abort command stops the transfer without raising completion and leaves the current address where it was. Later data-port strobes are ignored.
- R9: Word mode is bit 0 of offset 0x6, sampled when a transfer starts. In word mode each access moves two bytes and adds 2 to the address. The low byte (`[7:0]`) is at the current address and the high byte (`[15:8]`) is at the current address + 1.
- R10: In word mode an odd byte count is rounded up by one, so completion comes after ceil(count/2) accesses.
- R11: A read or write command with a byte count of zero raises completion at once, touches no buffer byte, and leaves the engine idle.
- R12: The current address wraps modulo 2^16, and buffer indexing uses its low address bits.
- R13: Command field values other than 001, 010 and 100 (including 011) leave an active transfer running unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_wr | input | 1 | Register write strobe |
| hs_addr | input | 4 | Register offset for writes and readback |
| hs_wdata | input | 8 | Register write data |
| hs_rdata | output | 8 | Register readback for `hs_addr` |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data, valid the cycle after `dp_rd` |

## Verification
The hardest case to reach is a data-port strobe that arrives after the engine has already left its active state, either through completion or through abort. Such a strobe must leave no trace. The bench first fills the neighbouring buffer bytes with known values through an ordinary transfer. It then finishes or aborts a second transfer, issues a stray strobe, and reads the region back through a fresh read transfer. A wrongly stored byte therefore shows up at the data port. Odd-count rounding in word mode is reached by programming five bytes and checking that completion appears on the third word access and not before.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int ADDR_W   = 16;
    localparam int DONE_BIT = 6;

    typedef enum logic [2:0] {
        OP_NONE  = 3'b000,
        OP_READ  = 3'b001,
        OP_WRITE = 3'b010,
        OP_SEND  = 3'b011,
        OP_ABORT = 3'b100
    } dma_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;

    localparam logic [3:0] OFS_CMD   = 4'h0;
    localparam logic [3:0] OFS_SA_LO = 4'h1;
    localparam logic [3:0] OFS_SA_HI = 4'h2;
    localparam logic [3:0] OFS_BC_LO = 4'h3;
    localparam logic [3:0] OFS_BC_HI = 4'h4;
    localparam logic [3:0] OFS_STAT  = 4'h5;
    localparam logic [3:0] OFS_CFG   = 4'h6;
endpackage

// File: rtl/rdma_cfg_regs.sv
module rdma_cfg_regs
    import rdma_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_wr,
    input  logic [3:0]    hs_addr,
    input  logic [7:0]    hs_wdata,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] byte_cnt,
    output logic          word_mode
);
    localparam int HI_W = AW - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_addr <= '0;
            byte_cnt   <= '0;
            word_mode  <= 1'b0;
        end else if (hs_wr) begin
            unique case (hs_addr)
                OFS_SA_LO: start_addr[7:0]     <= hs_wdata;
                OFS_SA_HI: start_addr[AW-1:8]  <= hs_wdata[HI_W-1:0];
                OFS_BC_LO: byte_cnt[7:0]       <= hs_wdata;
                OFS_BC_HI: byte_cnt[AW-1:8]    <= hs_wdata[HI_W-1:0];
                OFS_CFG:   word_mode           <= hs_wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic [2:0]    cmd_op,
    input  logic          stat_wr,
    input  logic          stat_clr,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] byte_cnt,
    input  logic          word_mode,
    input  logic          dp_rd,
    input  logic          dp_wr,
    output logic [AW-1:0] cur_addr,
    output logic          done,
    output logic          acc_rd,
    output logic          acc_wr,
    output logic          acc_wide
);
    localparam int REM_W = AW + 1;

    eng_state_e       state_q, state_d;
    logic [REM_W-1:0] rem_q, eff_cnt, step_rem;
    logic [AW-1:0]    cur_q, step_addr;
    logic             mode_q, done_q;
    logic             start_req, abort_req, acc, last, done_set;

    assign start_req = cmd_go && (cmd_op == OP_READ || cmd_op == OP_WRITE);
    assign abort_req = cmd_go && (cmd_op == OP_ABORT);
    assign eff_cnt   = word_mode ? ({1'b0, byte_cnt} + {{AW{1'b0}}, byte_cnt[0]})
                                 : {1'b0, byte_cnt};
    assign step_rem  = {{(REM_W-2){1'b0}}, mode_q, ~mode_q};
    assign step_addr = {{(AW-2){1'b0}}, mode_q, ~mode_q};
    assign last      = (rem_q == step_rem);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        acc_rd   = 1'b0;
        acc_wr   = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_READ: begin
                acc_rd = dp_rd && !start_req && !abort_req;
                if (acc_rd && last) state_d = ST_IDLE;
            end
            ST_WRITE: begin
                acc_wr = dp_wr && !start_req && !abort_req;
                if (acc_wr && last) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
        if (abort_req) state_d = ST_IDLE;
        if (start_req) begin
            if (eff_cnt == '0)            state_d = ST_IDLE;
            else if (cmd_op == OP_READ)   state_d = ST_READ;
            else                          state_d = ST_WRITE;
        end
    end

    assign acc      = acc_rd || acc_wr;
    assign done_set = (start_req && eff_cnt == '0) || (acc && last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            rem_q  <= '0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (start_req) begin
                cur_q  <= start_addr;
                rem_q  <= eff_cnt;
                mode_q <= word_mode;
            end else if (acc) begin
                cur_q  <= cur_q + step_addr;
                rem_q  <= rem_q - step_rem;
            end
            if (done_set)                 done_q <= 1'b1;
            else if (stat_wr && stat_clr) done_q <= 1'b0;
        end
    end

    assign cur_addr = cur_q;
    assign done     = done_q;
    assign acc_wide = mode_q;

    assert_last_access_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && last |=> state_q == ST_IDLE && done_q);
    assert_abort_goes_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> state_q == ST_IDLE);
    assert_zero_count_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && eff_cnt == '0 |=> done_q && state_q == ST_IDLE);
    assert_address_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> cur_q == $past(cur_q) + ($past(mode_q) ? 16'd2 : 16'd1));
    assert_word_count_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE && mode_q |-> rem_q[0] == 1'b0);
    assert_clear_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && stat_clr && !done_set |=> !done_q);
    assert_other_code_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go && !start_req && !abort_req && !acc |=> state_q == $past(state_q));
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf #(
    parameter int BUF_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUF_AW-1:0] idx,
    input  logic              we,
    input  logic              re,
    input  logic              wide,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int DEPTH = 1 << BUF_AW;

    logic [7:0]        mem [DEPTH];
    logic [BUF_AW-1:0] idx_hi;

    assign idx_hi = idx + 1'b1;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata[7:0];
            if (wide) mem[idx_hi] <= wdata[15:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= {(wide ? mem[idx_hi] : 8'h00), mem[idx]};
    end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hs_wr,
    input  logic [3:0]  hs_addr,
    input  logic [7:0]  hs_wdata,
    output logic [7:0]  hs_rdata,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic [15:0] dp_wdata,
    output logic [15:0] dp_rdata
);
    logic [ADDR_W-1:0] start_addr, byte_cnt, cur_addr;
    logic              word_mode, done, acc_rd, acc_wr, acc_wide;

    rdma_cfg_regs #(.AW(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_wr      (hs_wr),
        .hs_addr    (hs_addr),
        .hs_wdata   (hs_wdata),
        .start_addr (start_addr),
        .byte_cnt   (byte_cnt),
        .word_mode  (word_mode)
    );

    rdma_ctrl #(.AW(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (hs_wr && hs_addr == OFS_CMD),
        .cmd_op     (hs_wdata[5:3]),
        .stat_wr    (hs_wr && hs_addr == OFS_STAT),
        .stat_clr   (hs_wdata[DONE_BIT]),
        .start_addr (start_addr),
        .byte_cnt   (byte_cnt),
        .word_mode  (word_mode),
        .dp_rd      (dp_rd),
        .dp_wr      (dp_wr),
        .cur_addr   (cur_addr),
        .done       (done),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .acc_wide   (acc_wide)
    );

    rdma_buf #(.BUF_AW(BUF_AW)) buf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (cur_addr[BUF_AW-1:0]),
        .we    (acc_wr),
        .re    (acc_rd),
        .wide  (acc_wide),
        .wdata (dp_wdata),
        .rdata (dp_rdata)
    );

    always_comb begin
        unique case (hs_addr)
            OFS_SA_LO: hs_rdata = cur_addr[7:0];
            OFS_SA_HI: hs_rdata = cur_addr[15:8];
            OFS_STAT:  hs_rdata = 8'(done) << DONE_BIT;
            OFS_CFG:   hs_rdata = {7'b0, word_mode};
            default:   hs_rdata = 8'h00;
        endcase
    end

    assert_idle_port_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(dp_rdata));
endmodule

// File: tb/rdma_engine_tb_top.sv
module rdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_wr = 1'b0;
    logic [3:0]  hs_addr = 4'h0;
    logic [7:0]  hs_wdata = 8'h00;
    logic [7:0]  hs_rdata;
    logic        dp_rd = 1'b0;
    logic        dp_wr = 1'b0;
    logic [15:0] dp_wdata = 16'h0;
    logic [15:0] dp_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    rdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .hs_wr(hs_wr), .hs_addr(hs_addr),
        .hs_wdata(hs_wdata), .hs_rdata(hs_rdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] ofs, input logic [7:0] d);
        @(negedge clk);
        hs_wr = 1'b1; hs_addr = ofs; hs_wdata = d;
        @(negedge clk);
        hs_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [3:0] ofs, output logic [7:0] d);
        @(negedge clk);
        hs_addr = ofs;
        #1 d = hs_rdata;
    endtask

    task automatic cur_rd(output logic [15:0] a);
        logic [7:0] lo, hi;
        host_rd(4'h1, lo);
        host_rd(4'h2, hi);
        a = {hi, lo};
    endtask

    task automatic dp_write(input logic [15:0] d);
        @(negedge clk);
        dp_wr = 1'b1; dp_wdata = d;
        @(negedge clk);
        dp_wr = 1'b0;
    endtask

    task automatic dp_read(output logic [15:0] d);
        @(negedge clk);
        dp_rd = 1'b1;
        @(negedge clk);
        dp_rd = 1'b0;
        d = dp_rdata;
    endtask

    // op: 1 read, 2 write, 4 abort (command field bits 5:3)
    task automatic setup(input logic [15:0] sa, input logic [15:0] cnt, input logic [2:0] op);
        host_wr(4'h1, sa[7:0]);
        host_wr(4'h2, sa[15:8]);
        host_wr(4'h3, cnt[7:0]);
        host_wr(4'h4, cnt[15:8]);
        host_wr(4'h0, {2'b00, op, 3'b000});
    endtask

    task automatic fill(input logic [15:0] sa, input int n, input logic [7:0] base);
        setup(sa, 16'(n), 3'b010);
        for (int i = 0; i < n; i++) begin
            dp_write({8'h00, base + 8'(i)});
            exp_mem[8'(sa + 16'(i))] = base + 8'(i);
        end
        host_wr(4'h5, 8'h40);
    endtask

    task automatic t_reset;
        logic [15:0] a; logic [7:0] s;
        cur_rd(a);
        check("R1 current address after reset", a, 16'h0000);
        host_rd(4'h5, s);
        check("R1 status after reset", s, 8'h00);
        check("R1 data port after reset", dp_rdata, 16'h0000);
    endtask

    task automatic t_byte_write;
        logic [15:0] a; logic [7:0] s;
        fill(16'h0010, 6, 8'h30);
        setup(16'h0010, 16'd2, 3'b010);
        cur_rd(a);
        check("R2 start address copied", a, 16'h0010);
        dp_write(16'h00C1);
        cur_rd(a);
        check("R5 address mid transfer", a, 16'h0011);
        host_rd(4'h5, s);
        check("R6 no early completion", s, 8'h00);
        dp_write(16'h00C2);
        exp_mem[8'h10] = 8'hC1; exp_mem[8'h11] = 8'hC2;
        host_rd(4'h5, s);
        check("R6 completion flag", s, 8'h40);
        dp_write(16'h00EE);
        cur_rd(a);
        check("R6 stray write leaves address", a, 16'h0012);
        host_wr(4'h5, 8'hBF);
        host_rd(4'h5, s);
        check("R7 write of zero keeps flag", s, 8'h40);
        host_wr(4'h5, 8'h40);
        host_rd(4'h5, s);
        check("R7 write of one clears flag", s, 8'h00);
    endtask

    task automatic t_byte_read;
        logic [15:0] d, a; logic [7:0] s;
        setup(16'h0010, 16'd4, 3'b001);
        for (int i = 0; i < 4; i++) begin
            dp_read(d);
            check("R4 byte read (R3 stored, R6 stray dropped)", d, {8'h00, exp_mem[8'h10 + 8'(i)]});
        end
        host_rd(4'h5, s);
        check("R6 read completion", s, 8'h40);
        dp_read(d);
        check("R6 stray read leaves data", d, {8'h00, exp_mem[8'h13]});
        cur_rd(a);
        check("R6 stray read leaves address", a, 16'h0014);
        host_wr(4'h5, 8'h40);
    endtask

    task automatic t_abort;
        logic [15:0] a, d; logic [7:0] s;
        fill(16'h0020, 8, 8'h50);
        setup(16'h0020, 16'd8, 3'b010);
        dp_write(16'h00A0);
        dp_write(16'h00A1);
        exp_mem[8'h20] = 8'hA0; exp_mem[8'h21] = 8'hA1;
        host_wr(4'h0, 8'h20);
        host_rd(4'h5, s);
        check("R8 abort raises no completion", s, 8'h00);
        cur_rd(a);
        check("R8 abort keeps address", a, 16'h0022);
        dp_write(16'h0099);
        cur_rd(a);
        check("R8 strobe after abort ignored", a, 16'h0022);
        setup(16'h0020, 16'd4, 3'b001);
        for (int i = 0; i < 4; i++) begin
            dp_read(d);
            check("R8 buffer after abort", d, {8'h00, exp_mem[8'h20 + 8'(i)]});
        end
        host_wr(4'h5, 8'h40);
    endtask

    task automatic t_other_codes;
        logic [15:0] a; logic [7:0] s;
        setup(16'h0040, 16'd3, 3'b010);
        dp_write(16'h0011);
        host_wr(4'h0, 8'h18);
        host_wr(4'h0, 8'h00);
        host_wr(4'h0, 8'h38);
        dp_write(16'h0022);
        host_rd(4'h5, s);
        check("R13 transfer still running", s, 8'h00);
        cur_rd(a);
        check("R13 address keeps advancing", a, 16'h0042);
        dp_write(16'h0033);
        exp_mem[8'h40] = 8'h11; exp_mem[8'h41] = 8'h22; exp_mem[8'h42] = 8'h33;
        host_rd(4'h5, s);
        check("R13 completes with original count", s, 8'h40);
        host_wr(4'h5, 8'h40);
    endtask

    task automatic t_zero;
        logic [15:0] a; logic [7:0] s;
        setup(16'h1234, 16'd0, 3'b010);
        host_rd(4'h5, s);
        check("R11 zero count completes at once", s, 8'h40);
        dp_write(16'h0066);
        cur_rd(a);
        check("R11 no access on zero count", a, 16'h1234);
        host_wr(4'h5, 8'h40);
        setup(16'h0050, 16'd0, 3'b001);
        host_rd(4'h5, s);
        check("R11 zero count read completes", s, 8'h40);
        host_wr(4'h5, 8'h40);
    endtask

    task automatic t_word;
        logic [15:0] a, d; logic [7:0] s;
        host_wr(4'h6, 8'h01);
        host_rd(4'h6, s);
        check("R9 word mode readback", s, 8'h01);
        setup(16'h0030, 16'd5, 3'b010);
        dp_write(16'hB1B0);
        dp_write(16'hB3B2);
        cur_rd(a);
        check("R9 address steps by two", a, 16'h0034);
        host_rd(4'h5, s);
        check("R10 no completion after four bytes", s, 8'h00);
        dp_write(16'hB5B4);
        host_rd(4'h5, s);
        check("R10 odd count rounded up", s, 8'h40);
        cur_rd(a);
        check("R10 final address", a, 16'h0036);
        host_wr(4'h5, 8'h40);
        for (int i = 0; i < 6; i++) exp_mem[8'h30 + 8'(i)] = 8'hB0 + 8'(i);
        setup(16'h0030, 16'd4, 3'b001);
        dp_read(d);
        check("R9 first word read", d, 16'hB1B0);
        dp_read(d);
        check("R9 second word read", d, 16'hB3B2);
        host_rd(4'h5, s);
        check("R9 word read completes", s, 8'h40);
        host_wr(4'h5, 8'h40);
        host_wr(4'h6, 8'h00);
    endtask

    task automatic t_wrap;
        logic [15:0] a, d; logic [7:0] s;
        setup(16'hFFFF, 16'd2, 3'b010);
        dp_write(16'h005A);
        cur_rd(a);
        check("R12 address wraps to zero", a, 16'h0000);
        dp_write(16'h005B);
        host_rd(4'h5, s);
        check("R12 wrapped transfer completes", s, 8'h40);
        host_wr(4'h5, 8'h40);
        setup(16'hFFFF, 16'd2, 3'b001);
        dp_read(d);
        check("R12 byte before wrap", d, 16'h005A);
        dp_read(d);
        check("R12 byte after wrap", d, 16'h005B);
        host_wr(4'h5, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte_write();
        t_byte_read();
        t_abort();
        t_other_codes();
        t_zero();
        t_word();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, all requirements unfinished, actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule